// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobe

This block drives a multiplexed five-digit decimal display and a data-transfer strobe from a finished conversion result. When an end-of-conversion pulse arrives, it captures the five BCD digits and the overrange flag. It then enables one digit line at a time, from the most significant digit down to the least. The BCD code of the enabled digit is presented on a shared 4-bit bus. The most significant slot lasts 201 clocks and every other slot lasts 200 clocks, so one full pass takes 1001 clocks. Passes repeat for as long as no new result arrives.

During the first pass after each result, an active-low strobe pulses once in the middle of every digit slot. The pulse lasts half a clock period, so a UART, a processor port or an external latch receives each digit exactly once. Later passes only refresh the display and carry no strobes.

When the captured result is out of range, the data bus is blanked. After the fifth strobe all digit lines go dark and stay dark until the reference-integrate-start pulse. Scanning then resumes with blank data, which makes the display blink.

All ports are plain level or pulse signals. Timing is fixed by the clock count, so there is no valid/ready handshake and no back-pressure: a receiver must take each digit while the strobe is low.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After reset and before the first end-of-conversion pulse, all digit enables are 0, the BCD bus is 0 and the strobe is 1.
- R2: The cycle after an end-of-conversion pulse, enable bit 4 (most significant) rises. Enables then step through bits 3, 2, 1 and 0 and wrap back to bit 4, with at most one bit high at any time.
- R3: Enable bit 4 stays high for 201 clocks. Each of bits 3 to 0 stays high for 200 clocks.
- R4: A strobe is a low level during the low half of one clock cycle. That cycle is the 101st cycle of the digit slot, i.e. 100 clocks after the enable rose.
- R5: Each end-of-conversion pulse produces exactly five strobes, one per digit in the first pass. Later passes carry none.
- R6: When enable bit k is high, the BCD bus carries `digits_i[4k+3:4k]` as captured at the end-of-conversion pulse. The bus changes in the same cycle as the enables and is 0 whenever no enable is high.
- R7: If `overrange_i` was 1 at the end-of-conversion pulse, the BCD bus is 0 in every cycle until the next end-of-conversion pulse.
- R8: In overrange, all enables are 0 from the cycle after the fifth strobe until a reference-integrate-start pulse. The cycle after that pulse, scanning restarts at bit 4 with no strobes.
- R9: A reference-integrate-start pulse has no effect unless the scan is suspended by R8.
- R10: An end-of-conversion pulse that arrives mid-scan restarts the scan at bit 4. It captures the new digits and produces five new strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its low phase also shapes the strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| digits_i | input | 20 | Five BCD digits; digit k at bits 4k+3:4k, digit 4 most significant |
| overrange_i | input | 1 | Overrange flag of the finished result |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse |
| ref_start_i | input | 1 | One-cycle reference-integrate-start pulse |
| digit_en_o | output | 5 | Positive-going digit enables, bit 4 most significant |
| bcd_o | output | 4 | BCD code of the enabled digit |
| strobe_n_o | output | 1 | Active-low half-clock transfer strobe |

## Verification
The main function is driven with the following patterns:
- **An ascending digit pattern over two full passes.** This separates the strobed first pass from the silent refresh pass.
- **An alternating 9/0 pattern.** This exposes a wrong digit-to-slot mapping.
- **A result arriving mid-scan.** This shows that the slot counter and the strobe budget restart together.
- **An overrange result, with a reference-start pulse sent both before and after the suspension.** This tells a correct blink apart from early resumption or an ignored resume.

The strobe is sampled in both clock phases. This catches a pulse that covers the whole cycle or falls in the wrong half.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned FIRST_LEN  = 201,
  parameter int unsigned DIGIT_LEN  = 200,
  parameter int unsigned STROBE_AT  = 100,
  localparam int unsigned CW = $clog2(FIRST_LEN + 1),
  localparam int unsigned IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          hold_i,
  output logic          run_o,
  output logic [IW-1:0] idx_o,
  output logic          at_strobe_o,
  output logic          last_digit_o,
  output logic          wrap_o
);
  localparam logic [IW-1:0] MSD = IW'(NUM_DIGITS - 1);

  logic          run_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_m1;
  logic          slot_end;

  assign len_m1       = (idx_q == MSD) ? CW'(FIRST_LEN - 1) : CW'(DIGIT_LEN - 1);
  assign slot_end     = (cnt_q == len_m1);
  assign run_o        = run_q;
  assign idx_o        = idx_q;
  assign at_strobe_o  = (cnt_q == CW'(STROBE_AT));
  assign last_digit_o = (idx_q == '0);
  assign wrap_o       = last_digit_o && slot_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= MSD;
      cnt_q <= '0;
    end else if (restart_i) begin
      run_q <= 1'b1;
      idx_q <= MSD;
      cnt_q <= '0;
    end else if (run_q && !hold_i) begin
      if (slot_end) begin
        cnt_q <= '0;
        idx_q <= (idx_q == '0) ? MSD : idx_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: slot counter never passes the longest slot
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= CW'(FIRST_LEN - 1)));

  // R3: the most significant slot hands over after its full length
  assert_first_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hold_i && !restart_i && idx_q == MSD && cnt_q == CW'(FIRST_LEN - 1))
    |=> (idx_q == MSD - 1'b1 && cnt_q == '0));
endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_i,
  input  logic ref_start_i,
  input  logic ovr_i,
  input  logic run_i,
  input  logic at_strobe_i,
  input  logic last_digit_i,
  input  logic wrap_i,
  output logic susp_o,
  output logic strobe_n_o
);
  logic first_q;
  logic susp_q;
  logic advance;
  logic susp_set;
  logic req;

  assign advance  = run_i && !susp_q;
  assign req      = advance && first_q && at_strobe_i;
  assign susp_set = req && ovr_i && last_digit_i;
  assign susp_o   = susp_q;

  // low only during the low phase of the strobe cycle
  assign strobe_n_o = ~(req & ~clk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      susp_q  <= 1'b0;
    end else if (eoc_i) begin
      first_q <= 1'b1;
      susp_q  <= 1'b0;
    end else begin
      if (susp_set || (advance && wrap_i)) first_q <= 1'b0;
      if (susp_set) susp_q <= 1'b1;
      else if (susp_q && ref_start_i) susp_q <= 1'b0;
    end
  end

  // R8: suspension only starts right after the final strobe
  assert_susp_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(req));

  // R5: no strobes once the strobed pass is over
  assert_no_late_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap_i && !eoc_i) |=> !first_q);
endmodule

// File: rtl/digit_mux.sv
module digit_mux
  import scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                        active_i,
  input  logic                        blank_i,
  input  logic [IW-1:0]               idx_i,
  input  logic [NUM_DIGITS*BCD_W-1:0] held_i,
  output logic [NUM_DIGITS-1:0]       en_o,
  output bcd_t                        bcd_o
);
  bcd_t sel [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
    assign en_o[g] = active_i && (idx_i == IW'(g));
    assign sel[g]  = en_o[g] ? held_i[g*BCD_W +: BCD_W] : '0;
  end

  always_comb begin
    bcd_o = '0;
    for (int i = 0; i < NUM_DIGITS; i++) bcd_o = bcd_o | sel[i];
    if (blank_i) bcd_o = '0;
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned FIRST_LEN  = 201,
  parameter int unsigned DIGIT_LEN  = 200,
  parameter int unsigned STROBE_AT  = 100,
  localparam int unsigned IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int unsigned DW = NUM_DIGITS * BCD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         digits_i,
  input  logic                  overrange_i,
  input  logic                  eoc_i,
  input  logic                  ref_start_i,
  output logic [NUM_DIGITS-1:0] digit_en_o,
  output logic [BCD_W-1:0]      bcd_o,
  output logic                  strobe_n_o
);
  logic [DW-1:0] held_q;
  logic          ovr_q;
  logic          run;
  logic          susp;
  logic          restart;
  logic [IW-1:0] idx;
  logic          at_strobe;
  logic          last_digit;
  logic          wrap;
  bcd_t          bcd;

  assign restart = eoc_i || (susp && ref_start_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      ovr_q  <= 1'b0;
    end else if (eoc_i) begin
      held_q <= digits_i;
      ovr_q  <= overrange_i;
    end
  end

  scan_timer #(
    .NUM_DIGITS(NUM_DIGITS), .FIRST_LEN(FIRST_LEN),
    .DIGIT_LEN(DIGIT_LEN), .STROBE_AT(STROBE_AT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .hold_i(susp),
    .run_o(run), .idx_o(idx), .at_strobe_o(at_strobe),
    .last_digit_o(last_digit), .wrap_o(wrap)
  );

  strobe_ctrl u_strobe (
    .clk(clk), .rst_n(rst_n), .eoc_i(eoc_i), .ref_start_i(ref_start_i),
    .ovr_i(ovr_q), .run_i(run), .at_strobe_i(at_strobe),
    .last_digit_i(last_digit), .wrap_i(wrap),
    .susp_o(susp), .strobe_n_o(strobe_n_o)
  );

  digit_mux #(.NUM_DIGITS(NUM_DIGITS)) u_mux (
    .active_i(run && !susp), .blank_i(ovr_q), .idx_i(idx),
    .held_i(held_q), .en_o(digit_en_o), .bcd_o(bcd)
  );

  assign bcd_o = bcd;

  // R2: never two digits at once
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_en_o));

  // R7: blanked data under overrange
  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (bcd_o == '0));

  // R8: dark display while suspended
  assert_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> (digit_en_o == '0));

  // R10: a new result restarts at the most significant digit
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_i |=> (digit_en_o == (NUM_DIGITS'(1) << (NUM_DIGITS - 1))));
endmodule

// File: tb/bcd_digit_scanner_tb_top.sv
module bcd_digit_scanner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] digits = '0;
  logic        overrange = 1'b0;
  logic        eoc = 1'b0;
  logic        ref_start = 1'b0;
  logic [4:0]  digit_en;
  logic [3:0]  bcd;
  logic        strobe_n;

  int nchk = 0;
  int nfail = 0;
  int strobes = 0;

  always #4 clk = ~clk;

  bcd_digit_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .digits_i(digits), .overrange_i(overrange),
    .eoc_i(eoc), .ref_start_i(ref_start),
    .digit_en_o(digit_en), .bcd_o(bcd), .strobe_n_o(strobe_n)
  );

  // behavioural reference: one position counter over a 1001-clock pass
  bit          m_run, m_first, m_ovr, m_susp;
  int          m_t;
  logic [19:0] m_held;

  function automatic int slot_of(int t);
    return (t < 201) ? 4 : 3 - (t - 201) / 200;
  endfunction

  function automatic logic [4:0] exp_en();
    if (!m_run || m_susp) return 5'b0;
    return 5'b1 << slot_of(m_t);
  endfunction

  function automatic logic [3:0] exp_bcd();
    if (exp_en() == 0 || m_ovr) return 4'h0;
    return m_held[slot_of(m_t)*4 +: 4];
  endfunction

  function automatic bit exp_req();
    if (!m_run || m_susp || !m_first) return 1'b0;
    return (m_t < 201) ? (m_t == 100) : (((m_t - 201) % 200) == 100);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_first = 0; m_ovr = 0; m_susp = 0; m_t = 0; m_held = '0;
    end else if (eoc) begin
      m_run = 1; m_first = 1; m_ovr = overrange; m_susp = 0; m_t = 0; m_held = digits;
    end else if (m_run) begin
      if (m_susp) begin
        if (ref_start) begin m_susp = 0; m_t = 0; end
      end else if (m_ovr && m_first && m_t == 901) begin
        m_susp = 1; m_first = 0;
      end else begin
        if (m_t == 1000) m_first = 0;
        m_t = (m_t + 1) % 1001;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // high-phase sample: enables, data, strobe idle
  initial forever begin
    @(posedge clk); #2;
    if (!m_run) chk("R1 enables idle", 32'(digit_en), 32'(exp_en()));
    else if (m_susp) chk("R8 suspended enables", 32'(digit_en), 32'(exp_en()));
    else chk("R2 R3 enable sequence", 32'(digit_en), 32'(exp_en()));
    chk(m_ovr ? "R7 blanked data" : "R6 data bus", 32'(bcd), 32'(exp_bcd()));
    chk("R4 strobe high in high phase", 32'(strobe_n), 32'd1);
  end

  // low-phase sample: strobe position
  initial forever begin
    @(negedge clk); #2;
    chk("R4 strobe position", 32'(strobe_n), 32'(!exp_req()));
    if (!strobe_n) strobes++;
  end

  task automatic pulse_eoc(logic [19:0] d, bit ovr);
    @(posedge clk); #1;
    digits = d; overrange = ovr; eoc = 1'b1; strobes = 0;
    @(posedge clk); #1;
    eoc = 1'b0; digits = ~d;
  endtask

  task automatic pulse_ref();
    @(posedge clk); #1; ref_start = 1'b1;
    @(posedge clk); #1; ref_start = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    wait_cyc(4);
    #1 rst_n = 1'b1;
    wait_cyc(3);
    #1 chk("R1 reset enables", 32'(digit_en), 32'd0);
    chk("R1 reset strobe", 32'(strobe_n), 32'd1);

    // ascending pattern, two passes
    pulse_eoc(20'h54321, 1'b0);
    #1 chk("R2 first slot is bit 4", 32'(digit_en), 32'h10);
    wait_cyc(2100);
    chk("R5 five strobes per result", 32'(strobes), 32'd5);

    // reference start outside suspension is ignored
    pulse_ref();
    #1 chk("R9 scan continues", 32'(digit_en != 0), 32'd1);

    // mid-scan restart
    pulse_eoc(20'h90709, 1'b0);
    wait_cyc(450);
    pulse_eoc(20'h13579, 1'b0);
    #1 chk("R10 restart at bit 4", 32'(digit_en), 32'h10);
    chk("R10 new data", 32'(bcd), 32'h1);
    wait_cyc(1100);
    chk("R10 fresh five strobes", 32'(strobes), 32'd5);

    // overrange: early ref pulse ignored, then suspension and resume
    pulse_eoc(20'h88888, 1'b1);
    wait_cyc(300);
    pulse_ref();
    #1 chk("R9 early ref ignored", 32'(digit_en), 32'h08);
    wait_cyc(800);
    chk("R8 dark after final strobe", 32'(digit_en), 32'd0);
    chk("R5 five strobes in overrange", 32'(strobes), 32'd5);
    wait_cyc(300);
    pulse_ref();
    #1 chk("R8 resume at bit 4", 32'(digit_en), 32'h10);
    chk("R7 resumed data blank", 32'(bcd), 32'h0);
    wait_cyc(1100);
    chk("R8 no strobes after resume", 32'(strobes), 32'd5);

    // alternating pattern
    pulse_eoc(20'h90909, 1'b0);
    wait_cyc(1100);
    chk("R5 five strobes alternating", 32'(strobes), 32'd5);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule